// File: doc/BRIEF.md
# Cascade Stage Evaluator

This block scores one stage of a boosted cascade of rectangle features over a detection window. Each clock cycle it can accept one feature. A feature is described by the integral-image corner values of up to three rectangles, a signed weight for each rectangle, a feature threshold and two vote values. For each rectangle the block forms the box sum from its corners and multiplies it by the rectangle's weight. The weighted sums are added to give the feature value.

The feature value is compared with the feature threshold scaled by the window area, so no divider is needed. The comparison selects one of the two votes. Votes are summed from the first feature of a stage through the feature flagged as last. The stage total is then compared with a stage threshold. A single-cycle done strobe reports the pass or reject outcome.

The corner values and feature parameters come from an external feature table and window buffer. Scheduling stages one after another is left to the surrounding logic.

Top module: `cascade_stage_eval`

## Requirements
- R1: For rectangle k, the corners are corner_i[4k] = a, corner_i[4k+1] = b, corner_i[4k+2] = c and corner_i[4k+3] = d. The values are unsigned, and the rectangle sum is a + d - b - c.
- R2: The feature value is the sum over the three rectangles of rect_wgt_i[k] × rectangle sum k. Each rect_wgt_i[k] is a 4-bit two's-complement weight.
- R3: A rectangle whose weight is zero adds nothing to the feature value, whatever its corner values are.
- R4: The feature casts yes_vote_i when its value is greater than or equal to feat_thr_i × win_area_i, and no_vote_i otherwise. feat_thr_i is signed and win_area_i is unsigned.
- R5: The stage total is the sum of the signed votes of every valid feature from the first feature after the previous last feature (or after reset) up to and including the feature with feat_last_i high.
- R6: The stage passes when its total is greater than or equal to the signed stage_thr_i that is presented with the last feature. Equality counts as a pass.
- R7: done_o is high for exactly one cycle, three rising edges after the last feature is sampled. pass_o carries the result in that cycle and is 0 in every other cycle.
- R8: A cycle with feat_valid_i low has no effect, whatever the other inputs hold. Features may arrive back-to-back or with idle gaps.
- R9: Synchronous reset clears any partial stage and the pipeline, and holds done_o and pass_o at 0.
- R10: A stage may consist of a single feature. A new stage may start in the cycle right after the previous stage's last feature.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| feat_valid_i | input | 1 | A feature is presented this cycle |
| feat_last_i | input | 1 | This feature closes the stage |
| corner_i | input | 12×16 | Integral corner values, four per rectangle |
| rect_wgt_i | input | 3×4 | Signed weight per rectangle |
| feat_thr_i | input | 12 | Signed feature threshold |
| win_area_i | input | 10 | Window area used to scale the threshold |
| yes_vote_i | input | 8 | Signed vote when the threshold is met |
| no_vote_i | input | 8 | Signed vote otherwise |
| stage_thr_i | input | 15 | Signed stage threshold, taken with the last feature |
| done_o | output | 1 | Stage result strobe |
| pass_o | output | 1 | Stage passed (valid with done_o) |

## Verification
Stage results are due on the third rising edge after the last feature is sampled. When the driver sends a last feature, it records the current cycle number plus three, together with the expected decision. The monitor samples on falling edges. On every done strobe it compares the current cycle number with that due value and compares the decision, and it reports any strobe that arrives with no pending expectation. Boundary cases include equality at both thresholds, zero-weight rectangles with large corners, negative thresholds, back-to-back stages, idle gaps filled with junk, and a reset in the middle of a stage.

// File: rtl/cascade_pkg.sv
`timescale 1ns/1ps
package cascade_pkg;
    parameter int INT_W    = 16;
    parameter int N_RECT   = 3;
    parameter int WGT_W    = 4;
    parameter int THR_W    = 12;
    parameter int AREA_W   = 10;
    parameter int VOTE_W   = 8;
    parameter int MAX_FEAT = 64;

    localparam int N_CORNER = 4 * N_RECT;
    localparam int RECT_W   = INT_W + 2;
    localparam int PROD_W   = RECT_W + WGT_W;
    localparam int FEAT_W   = PROD_W + $clog2(N_RECT) + 1;
    localparam int SCL_W    = THR_W + AREA_W + 1;
    localparam int CMP_W    = ((FEAT_W > SCL_W) ? FEAT_W : SCL_W) + 1;
    localparam int ACC_W    = VOTE_W + $clog2(MAX_FEAT) + 1;

    typedef logic signed [RECT_W-1:0] rect_t;
    typedef logic signed [FEAT_W-1:0] feat_t;
    typedef logic signed [SCL_W-1:0]  scl_t;
    typedef logic signed [CMP_W-1:0]  cmp_t;
    typedef logic signed [VOTE_W-1:0] vote_t;
    typedef logic signed [ACC_W-1:0]  acc_t;

    // after box sums
    typedef struct packed {
        logic                           valid;
        logic                           last;
        rect_t [N_RECT-1:0]             rect;
        logic  [N_RECT-1:0][WGT_W-1:0]  wgt;
        scl_t                           thr_scl;
        vote_t                          yes_v;
        vote_t                          no_v;
        acc_t                           stage_thr;
    } s1_t;

    // after weighting
    typedef struct packed {
        logic   valid;
        logic   last;
        feat_t  feat;
        scl_t   thr_scl;
        vote_t  yes_v;
        vote_t  no_v;
        acc_t   stage_thr;
    } s2_t;

    function automatic rect_t box_sum(input logic [INT_W-1:0] a, input logic [INT_W-1:0] b,
                                      input logic [INT_W-1:0] c, input logic [INT_W-1:0] d);
        rect_t ea, eb, ec, ed;
        ea = rect_t'({2'b00, a});
        eb = rect_t'({2'b00, b});
        ec = rect_t'({2'b00, c});
        ed = rect_t'({2'b00, d});
        return ea + ed - eb - ec;
    endfunction

    function automatic logic meets_scaled(input feat_t f, input scl_t s);
        return cmp_t'(f) >= cmp_t'(s);
    endfunction
endpackage

// File: rtl/stage_rect_unit.sv
`timescale 1ns/1ps
module stage_rect_unit
    import cascade_pkg::*;
(
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              in_valid,
    input  logic                              in_last,
    input  logic [N_CORNER-1:0][INT_W-1:0]    corners,
    input  logic [N_RECT-1:0][WGT_W-1:0]      wgt,
    input  logic [THR_W-1:0]                  feat_thr,
    input  logic [AREA_W-1:0]                 area,
    input  logic [VOTE_W-1:0]                 yes_v,
    input  logic [VOTE_W-1:0]                 no_v,
    input  logic [ACC_W-1:0]                  stage_thr,
    output s1_t                               s1_q
);
    rect_t [N_RECT-1:0] rect_d;
    scl_t               thr_scl_d;

    for (genvar k = 0; k < N_RECT; k++) begin : g_box
        assign rect_d[k] = box_sum(corners[4*k], corners[4*k+1], corners[4*k+2], corners[4*k+3]);
    end

    assign thr_scl_d = scl_t'($signed(feat_thr)) * scl_t'($signed({1'b0, area}));

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q <= '0;
        end else begin
            s1_q.valid     <= in_valid;
            s1_q.last      <= in_valid & in_last;
            s1_q.rect      <= rect_d;
            s1_q.wgt       <= wgt;
            s1_q.thr_scl   <= thr_scl_d;
            s1_q.yes_v     <= yes_v;
            s1_q.no_v      <= no_v;
            s1_q.stage_thr <= stage_thr;
        end
    end
endmodule

// File: rtl/stage_weight_unit.sv
`timescale 1ns/1ps
module stage_weight_unit
    import cascade_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  s1_t  s1_i,
    output s2_t  s2_q
);
    feat_t feat_d;

    always_comb begin
        feat_d = '0;
        for (int k = 0; k < N_RECT; k++) begin
            feat_d = feat_d + feat_t'($signed(s1_i.rect[k])) * feat_t'($signed(s1_i.wgt[k]));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s2_q <= '0;
        end else begin
            s2_q.valid     <= s1_i.valid;
            s2_q.last      <= s1_i.last;
            s2_q.feat      <= feat_d;
            s2_q.thr_scl   <= s1_i.thr_scl;
            s2_q.yes_v     <= s1_i.yes_v;
            s2_q.no_v      <= s1_i.no_v;
            s2_q.stage_thr <= s1_i.stage_thr;
        end
    end

    // R3
    zero_wgt_chk: assert property (@(posedge clk) disable iff (rst)
        (s1_i.valid && s1_i.wgt == '0) |=> (s2_q.feat == '0));
endmodule

// File: rtl/stage_vote_unit.sv
`timescale 1ns/1ps
module stage_vote_unit
    import cascade_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  s2_t  s2_i,
    output logic done_q,
    output logic pass_q
);
    acc_t  acc_q;
    acc_t  total;
    vote_t vote;
    logic  take_yes;

    assign take_yes = meets_scaled(s2_i.feat, s2_i.thr_scl);
    assign vote     = take_yes ? s2_i.yes_v : s2_i.no_v;
    assign total    = acc_q + acc_t'(vote);

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q  <= '0;
            done_q <= 1'b0;
            pass_q <= 1'b0;
        end else begin
            done_q <= s2_i.valid & s2_i.last;
            pass_q <= s2_i.valid & s2_i.last & ($signed(total) >= $signed(s2_i.stage_thr));
            if (s2_i.valid) begin
                acc_q <= s2_i.last ? acc_t'(0) : total;
            end
        end
    end

    // R5
    acc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !s2_i.valid |=> $stable(acc_q));
endmodule

// File: rtl/cascade_stage_eval.sv
`timescale 1ns/1ps
module cascade_stage_eval
    import cascade_pkg::*;
(
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            feat_valid_i,
    input  logic                            feat_last_i,
    input  logic [N_CORNER-1:0][INT_W-1:0]  corner_i,
    input  logic [N_RECT-1:0][WGT_W-1:0]    rect_wgt_i,
    input  logic [THR_W-1:0]                feat_thr_i,
    input  logic [AREA_W-1:0]               win_area_i,
    input  logic [VOTE_W-1:0]               yes_vote_i,
    input  logic [VOTE_W-1:0]               no_vote_i,
    input  logic [ACC_W-1:0]                stage_thr_i,
    output logic                            done_o,
    output logic                            pass_o
);
    s1_t s1;
    s2_t s2;

    stage_rect_unit u_rect (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (feat_valid_i),
        .in_last   (feat_last_i),
        .corners   (corner_i),
        .wgt       (rect_wgt_i),
        .feat_thr  (feat_thr_i),
        .area      (win_area_i),
        .yes_v     (yes_vote_i),
        .no_v      (no_vote_i),
        .stage_thr (stage_thr_i),
        .s1_q      (s1)
    );

    stage_weight_unit u_weight (
        .clk  (clk),
        .rst  (rst),
        .s1_i (s1),
        .s2_q (s2)
    );

    stage_vote_unit u_vote (
        .clk    (clk),
        .rst    (rst),
        .s2_i   (s2),
        .done_q (done_o),
        .pass_q (pass_o)
    );

    // R7
    done_latency_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> $past(feat_valid_i && feat_last_i, 3));

    // R7
    pass_gated_chk: assert property (@(posedge clk) disable iff (rst)
        pass_o |-> done_o);
endmodule

// File: tb/cascade_stage_eval_tb_top.sv
`timescale 1ns/1ps
module cascade_stage_eval_tb_top;
    import cascade_pkg::*;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic                            rst;
    logic                            feat_valid_i;
    logic                            feat_last_i;
    logic [N_CORNER-1:0][INT_W-1:0]  corner_i;
    logic [N_RECT-1:0][WGT_W-1:0]    rect_wgt_i;
    logic [THR_W-1:0]                feat_thr_i;
    logic [AREA_W-1:0]               win_area_i;
    logic [VOTE_W-1:0]               yes_vote_i;
    logic [VOTE_W-1:0]               no_vote_i;
    logic [ACC_W-1:0]                stage_thr_i;
    logic                            done_o;
    logic                            pass_o;

    cascade_stage_eval dut_i (
        .clk(clk), .rst(rst), .feat_valid_i(feat_valid_i), .feat_last_i(feat_last_i),
        .corner_i(corner_i), .rect_wgt_i(rect_wgt_i), .feat_thr_i(feat_thr_i),
        .win_area_i(win_area_i), .yes_vote_i(yes_vote_i), .no_vote_i(no_vote_i),
        .stage_thr_i(stage_thr_i), .done_o(done_o), .pass_o(pass_o)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0;
    int n_fail = 0;
    int exp_acc = 0;
    int area_g = 1;
    int q_pass[$];
    int q_due[$];
    bit finished = 1'b0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (!rst && !finished) begin
            if (pass_o && !done_o) check(1'b0, "R7 pass without done", 1, 0);
            if (done_o) begin
                if (q_pass.size() == 0) begin
                    check(1'b0, "R7 unexpected done", 1, 0);
                end else begin
                    int ep;
                    int ed;
                    ep = q_pass.pop_front();
                    ed = q_due.pop_front();
                    check(cyc == ed, "R7 done latency", cyc, ed);
                    check(int'(pass_o) == ep, "R5/R6 stage decision", int'(pass_o), ep);
                end
            end
        end
    end

    // driver: one feature per call; a0 >= 0 forces rectangle 0 to sum a0
    task automatic send(input int seed, input int a0, input int w0, input int w1, input int w2,
                        input int thr, input int yv, input int nv, input bit last, input int sthr);
        int c[N_CORNER];
        int r[N_RECT];
        int w[N_RECT];
        int f;
        int vote;
        for (int i = 0; i < N_CORNER; i++) c[i] = (seed * 7919 + i * 613 + 17) % 5000;
        if (a0 >= 0) begin
            c[0] = a0; c[1] = 0; c[2] = 0; c[3] = 0;
        end
        w[0] = w0; w[1] = w1; w[2] = w2;
        f = 0;
        for (int k = 0; k < N_RECT; k++) begin
            r[k] = c[4*k] + c[4*k+3] - c[4*k+1] - c[4*k+2];
            f = f + w[k] * r[k];
        end
        vote = (f >= thr * area_g) ? yv : nv;
        exp_acc = exp_acc + vote;
        @(negedge clk);
        feat_valid_i = 1'b1;
        feat_last_i  = last;
        for (int i = 0; i < N_CORNER; i++) corner_i[i] = c[i][INT_W-1:0];
        for (int k = 0; k < N_RECT; k++) rect_wgt_i[k] = w[k][WGT_W-1:0];
        feat_thr_i  = thr[THR_W-1:0];
        win_area_i  = area_g[AREA_W-1:0];
        yes_vote_i  = yv[VOTE_W-1:0];
        no_vote_i   = nv[VOTE_W-1:0];
        stage_thr_i = sthr[ACC_W-1:0];
        if (last) begin
            q_pass.push_back((exp_acc >= sthr) ? 1 : 0);
            q_due.push_back(cyc + 3);
            exp_acc = 0;
        end
    endtask

    // idle cycles with junk on every data input (R8)
    task automatic idle(input int n, input int seed);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            feat_valid_i = 1'b0;
            feat_last_i  = 1'b1;
            for (int j = 0; j < N_CORNER; j++) corner_i[j] = INT_W'((seed + i) * 4099 + j * 257);
            rect_wgt_i  = '1;
            feat_thr_i  = THR_W'(seed * 3 + 999);
            yes_vote_i  = VOTE_W'(-100);
            no_vote_i   = VOTE_W'(100);
            stage_thr_i = ACC_W'(seed * 77);
        end
    endtask

    initial begin
        rst = 1'b1;
        feat_valid_i = 1'b0; feat_last_i = 1'b0; corner_i = '0; rect_wgt_i = '0;
        feat_thr_i = '0; win_area_i = '0; yes_vote_i = '0; no_vote_i = '0; stage_thr_i = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9 reset state
        check(done_o == 1'b0, "R9 done after reset", int'(done_o), 0);
        check(pass_o == 1'b0, "R9 pass after reset", int'(pass_o), 0);

        // R1/R2: mixed weights, back-to-back features (R8)
        area_g = 1;
        send(1, -1,  1, -2,  0, 0, 20, -5, 1'b0, 10);
        send(2, -1, -1,  2,  1, 0, 20, -5, 1'b0, 10);
        send(3, -1,  2, -1, -1, 0, 20, -5, 1'b1, 10);

        // R4 boundary with area 5: 100 >= 20*5 yes, 99 no; R6 equality passes (7 >= 7)
        area_g = 5;
        send(4, 100, 1, 0, 0, 20, 10, -3, 1'b0, 0);
        send(5,  99, 1, 0, 0, 20, 10, -3, 1'b1, 7);
        idle(2, 9);
        // R6 total 7 against 8 fails; junk gaps inside the stage (R8)
        send(6, 100, 1, 0, 0, 20, 10, -3, 1'b0, 0);
        idle(3, 21);
        send(7,  99, 1, 0, 0, 20, 10, -3, 1'b1, 8);
        // R10 single-feature stage right after the previous last
        send(8, 40, 1, 0, 0, 5, 6, -6, 1'b1, 6);
        send(9, 10, 1, 0, 0, 5, 6, -6, 1'b1, 0);

        // R3 zero weights with large corners elsewhere
        area_g = 1;
        send(1000, 500, 1, 0, 0, 500, 9, -9, 1'b1, 9);
        send(2000, 500, 1, 0, 0, 500, 9, -9, 1'b1, 9);
        send(3000, 500, 0, 0, 0, 1, 9, -9, 1'b1, 0);
        idle(2, 33);

        // negative thresholds and weights
        area_g = 7;
        send(11, 300, -1, 0, 0, -50, -4, -20, 1'b0, 0);
        send(12, 400, -1, 0, 0, -50, -4, -20, 1'b1, -20);
        send(13, 300, -1, 0, 0, -50, -4, -20, 1'b1, -3);
        idle(4, 44);

        // R9 reset in the middle of a stage clears partial votes
        area_g = 1;
        send(14, 50, 1, 0, 0, 0, -60, -60, 1'b0, 0);
        send(15, 50, 1, 0, 0, 0, -60, -60, 1'b0, 0);
        @(negedge clk);
        rst = 1'b1; feat_valid_i = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        exp_acc = 0;
        check(done_o == 1'b0, "R9 done held at reset", int'(done_o), 0);
        send(16, 50, 1, 0, 0, 0, 5, -5, 1'b1, 5);
        idle(1, 55);

        // assorted stages of 1..5 features
        for (int s = 0; s < 10; s++) begin
            int nf;
            nf = 1 + s % 5;
            area_g = 1 + s;
            for (int f = 0; f < nf; f++) begin
                send(s * 11 + f + 50, -1, ((s + f) % 15) - 7, ((s * 3 + f) % 15) - 7, ((s + 2 * f) % 15) - 7,
                     ((s * 37 + f * 53) % 200) - 100, ((s * 13 + f) % 100) - 30, -((s + f * 7) % 60),
                     f == nf - 1, (s % 3) * 20 - 10);
            end
            if (s % 2 == 1) idle(s % 3 + 1, s);
        end

        // long stage
        area_g = 3;
        for (int f = 0; f < 20; f++)
            send(f + 700, -1, (f % 15) - 7, 3, -2, (f * 17 % 100) - 50, 4, -1, f == 19, 20);

        idle(8, 66);
        // R7 every expected strobe arrived
        check(q_pass.size() == 0, "R7 missing done strobes", q_pass.size(), 0);
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule